// File: doc/BRIEF.md
# Custom-Sequence Three-Bit Counter

This block is a synchronous three-bit state counter. It steps through a fixed loop of five codes that is not in binary order: 000, 100, 111, 010, 011, and then back to 000. The counter is meant to sit inside a larger controller as a small sequencer, and its state bits drive decode logic downstream. The three codes that are not in the loop (001, 101 and 110) each have a fixed successor. A state word corrupted into one of them therefore falls back into the loop on its own.

The state is kept in two independent register copies. Both copies use the same next-state function. The first copy works like toggle flip-flops: each bit receives a toggle strobe equal to its wanted next value XOR its present value, and it flips only when that strobe is set. The second copy works like plain data flip-flops and loads the wanted next value directly. The `state` port reports the toggle-style copy. A combinational `mismatch` flag is raised whenever the two copies hold different codes, so any fault that breaks lockstep between them can be seen.

A small control module turns the reset and enable pins into a strobe struct, the datapath holds both copies, and a thin top module connects them.

Top module: `cseq_counter`

## Requirements
- R1: A clock edge with `rst` high puts both copies at 000, so `state` reads 000 and `mismatch` reads 0 after that edge.
- R2: With `en` high and `rst` low, each clock edge advances the state along the loop 000→100→111→010→011→000 (bit 2 is C, bit 1 is B, bit 0 is A), and the loop repeats without end.
- R3: A clock edge with `en` low and `rst` low leaves both copies unchanged.
- R4: The unused code 001 steps to 100 on an enabled edge.
- R5: The unused code 101 steps to 110 on an enabled edge.
- R6: The unused code 110 steps to 011 on an enabled edge.
- R7: From any unused code, at most two enabled edges bring the state into the five-code loop.
- R8: `mismatch` is high in exactly those cycles where the toggle-style copy and the data-style copy differ. When both copies start from a common reset, it stays low.
- R9: When `rst` and `en` are both high on the same edge, reset wins.
- R10: `state` presents the toggle-style copy. A disagreement between the copies therefore appears on `state` together with `mismatch`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of both copies |
| en | input | 1 | Count enable; low holds both copies |
| state | output | 3 | Toggle-style copy of the state, {C,B,A} |
| mismatch | output | 1 | High while the two copies disagree |

## Verification
Inputs are applied on the falling edge. The effect of that stimulus is due on `state` at the next rising edge, one register stage later. `mismatch` is combinational from both copies, so it is due in that same cycle. Each driver call queues exactly one expected pair for that edge, and the monitor takes one item off the queue 1 ns after every rising edge. Expected values and the edge they belong to therefore stay matched with no extra alignment logic. Unused codes are inserted into the registers during a reset edge and held across it. The first enabled edge after that shows the successor of the unused code, and the second edge shows the code in the loop that R7 requires.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  localparam int STW = 3;
  localparam int NCOPY = 2;

  typedef logic [STW-1:0] code_t;

  typedef struct packed {
    logic clr;
    logic step;
  } ctl_t;

  function automatic logic inLoop(input code_t c);
    return (c == 3'b000) || (c == 3'b100) || (c == 3'b111) ||
           (c == 3'b010) || (c == 3'b011);
  endfunction

endpackage

// File: rtl/cseq_next.sv
module cseq_next
  import cseq_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);

  always_comb begin
    case (cur)
      3'b000:  nxt = 3'b100;
      3'b100:  nxt = 3'b111;
      3'b111:  nxt = 3'b010;
      3'b010:  nxt = 3'b011;
      3'b011:  nxt = 3'b000;
      3'b001:  nxt = 3'b100;
      3'b101:  nxt = 3'b110;
      default: nxt = 3'b011;
    endcase
  end

endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
  import cseq_pkg::*;
(
  input  logic rst,
  input  logic en,
  output ctl_t ctl
);

  always_comb begin
    ctl.clr  = rst;
    ctl.step = en & ~rst;
  end

endmodule

// File: rtl/cseq_path.sv
module cseq_path
  import cseq_pkg::*;
(
  input  logic  clk,
  input  ctl_t  ctl,
  output code_t stateQ,
  output logic  mismatch
);

  code_t tglQ;
  code_t datQ;
  code_t cur [NCOPY];
  code_t nxt [NCOPY];
  code_t tIn;

  assign cur[0] = tglQ;
  assign cur[1] = datQ;

  generate
    for (genvar k = 0; k < NCOPY; k++) begin : g_nx
      cseq_next u_nx (
        .cur(cur[k]),
        .nxt(nxt[k])
      );
    end
  endgenerate

  // toggle strobe per bit: flip only where next differs from present
  assign tIn = nxt[0] ^ tglQ;

  always_ff @(posedge clk) begin
    if (ctl.clr)       tglQ <= '0;
    else if (ctl.step) tglQ <= tglQ ^ tIn;
  end

  always_ff @(posedge clk) begin
    if (ctl.clr)       datQ <= '0;
    else if (ctl.step) datQ <= nxt[1];
  end

  assign stateQ   = tglQ;
  assign mismatch = (tglQ != datQ);

  AST_ZERO_TO_FOUR: assert property (@(posedge clk) disable iff (ctl.clr)
    ctl.step && datQ == 3'b000 |=> datQ == 3'b100); // R2
  AST_TGL_SEVEN_TO_TWO: assert property (@(posedge clk) disable iff (ctl.clr)
    ctl.step && tglQ == 3'b111 |=> tglQ == 3'b010); // R2
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (ctl.clr)
    !ctl.step |=> $stable(tglQ) && $stable(datQ)); // R3
  AST_ONE_TO_FOUR: assert property (@(posedge clk) disable iff (ctl.clr)
    ctl.step && datQ == 3'b001 |=> datQ == 3'b100); // R4
  AST_FIVE_TO_SIX: assert property (@(posedge clk) disable iff (ctl.clr)
    ctl.step && datQ == 3'b101 |=> datQ == 3'b110); // R5
  AST_SIX_TO_THREE: assert property (@(posedge clk) disable iff (ctl.clr)
    ctl.step && datQ == 3'b110 |=> datQ == 3'b011); // R6
  AST_BACK_IN_LOOP: assert property (@(posedge clk) disable iff (ctl.clr)
    ctl.step && (datQ == 3'b001 || datQ == 3'b110) |=> inLoop(datQ)); // R7
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (ctl.clr)
    !mismatch |=> !mismatch); // R8

endmodule

// File: rtl/cseq_counter.sv
module cseq_counter
  import cseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  output logic [STW-1:0] state,
  output logic           mismatch
);

  ctl_t  ctl;
  code_t stateQ;

  cseq_ctrl u_ctrl (
    .rst(rst),
    .en (en),
    .ctl(ctl)
  );

  cseq_path u_path (
    .clk     (clk),
    .ctl     (ctl),
    .stateQ  (stateQ),
    .mismatch(mismatch)
  );

  assign state = stateQ;

endmodule

// File: tb/cseq_counter_tb.sv
module cseq_counter_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] state;
  logic       mismatch;

  typedef struct {
    logic [2:0] st;
    logic       mm;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  logic [2:0] modelT = 3'b000;
  logic [2:0] modelD = 3'b000;

  always #5 clk = ~clk;

  cseq_counter u_dut (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .state   (state),
    .mismatch(mismatch)
  );

  function automatic logic [2:0] refNext(input logic [2:0] c);
    case (c)
      3'b000:  return 3'b100;
      3'b100:  return 3'b111;
      3'b111:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b000;
      3'b001:  return 3'b100;
      3'b101:  return 3'b110;
      default: return 3'b011;
    endcase
  endfunction

  task automatic pushExp(input string tag);
    exp_t e;
    e.st  = modelT;
    e.mm  = (modelT != modelD);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic stepIt(input logic e_in, input logic r_in, input string tag);
    @(negedge clk);
    en  = e_in;
    rst = r_in;
    if (r_in) begin
      modelT = 3'b000;
      modelD = 3'b000;
    end else if (e_in) begin
      modelT = refNext(modelT);
      modelD = refNext(modelD);
    end
    pushExp(tag);
  endtask

  // place a code into one or both copies during a reset edge, then let go
  task automatic plant(input logic [2:0] c, input bit both, input string tag);
    @(negedge clk);
    en  = 1'b1;
    rst = 1'b1;
    case (c)
      3'b001: force u_dut.u_path.tglQ = 3'b001;
      3'b101: force u_dut.u_path.tglQ = 3'b101;
      3'b110: force u_dut.u_path.tglQ = 3'b110;
      default: force u_dut.u_path.tglQ = 3'b111;
    endcase
    if (both) begin
      case (c)
        3'b001: force u_dut.u_path.datQ = 3'b001;
        3'b101: force u_dut.u_path.datQ = 3'b101;
        3'b110: force u_dut.u_path.datQ = 3'b110;
        default: force u_dut.u_path.datQ = 3'b111;
      endcase
    end
    modelT = c;
    modelD = both ? c : 3'b000;
    pushExp(tag);
    @(posedge clk);
    #2;
    release u_dut.u_path.tglQ;
    if (both) release u_dut.u_path.datQ;
  endtask

  // monitor: one expected item per rising edge
  always begin : mon
    exp_t e;
    @(posedge clk);
    #1;
    if (!done && sb.size() > 0) begin
      e = sb.pop_front();
      total++;
      if (state !== e.st || mismatch !== e.mm) begin
        bad++;
        $display("FAIL %s: state=%b mismatch=%b expected state=%b mismatch=%b",
                 e.tag, state, mismatch, e.st, e.mm);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: state=%b mismatch=%b expected run to finish", state, mismatch);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : drive
    // R1: reset state
    stepIt(1'b0, 1'b1, "R1 reset");
    stepIt(1'b0, 1'b1, "R1 reset");
    // R2: three full loops plus one step
    for (int i = 0; i < 16; i++) stepIt(1'b1, 1'b0, "R2 loop order");
    // R3: hold with enable low
    for (int i = 0; i < 3; i++) stepIt(1'b0, 1'b0, "R3 hold");
    stepIt(1'b1, 1'b0, "R2 resume");
    stepIt(1'b1, 1'b0, "R2 resume");
    stepIt(1'b0, 1'b0, "R3 hold");
    // R9: reset beats enable mid-loop
    stepIt(1'b1, 1'b1, "R9 reset priority");
    stepIt(1'b1, 1'b0, "R1 restart");
    // R4, R5, R6, R7: unused codes in both copies
    plant(3'b001, 1'b1, "R7 plant 001");
    stepIt(1'b1, 1'b0, "R4 001 successor");
    stepIt(1'b1, 1'b0, "R7 in loop");
    plant(3'b101, 1'b1, "R7 plant 101");
    stepIt(1'b1, 1'b0, "R5 101 successor");
    stepIt(1'b1, 1'b0, "R7 in loop");
    plant(3'b110, 1'b1, "R7 plant 110");
    stepIt(1'b1, 1'b0, "R6 110 successor");
    stepIt(1'b1, 1'b0, "R7 in loop");
    stepIt(1'b0, 1'b0, "R3 hold after recovery");
    // R8, R10: toggle copy alone disturbed
    plant(3'b111, 1'b0, "R10 state shows toggle copy");
    stepIt(1'b1, 1'b0, "R8 copies still differ");
    stepIt(1'b0, 1'b1, "R8 common reset clears flag");
    for (int i = 0; i < 6; i++) stepIt(1'b1, 1'b0, "R8 lockstep");
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule